// File: doc/BRIEF.md
# Subtractive GCD Engine

This block finds the greatest common divisor of two unsigned operands using only subtraction. Two load-enabled registers hold the working values. A single internal bus feeds both registers. One of several sources drives that bus at a time: the two operand inputs, either register, or the ALU. The ALU only subtracts, and one function bit sets the direction of the subtraction. It reports a zero flag and a sign flag. A Moore controller steps through the algorithm, and its loop decisions use nothing but those two flags.

To use the block, place the operands on its inputs and pulse `start` while the block is idle or finished. The operands must stay unchanged until `done` rises. When the two working values are equal, the engine stops. It raises `done` and presents the result from register A. The result stays there until the next accepted start. If either operand is zero, a guard at start time skips the loop entirely, so the engine always terminates.

Top module: `gcd_sub_engine`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `done` is 0 and `result` is 0.
- R2: The ALU forms a (W+1)-bit difference of the zero-extended registers. It computes A−B when the function bit is 0 and B−A when it is 1. The zero flag is 1 exactly when the difference is zero. The negative flag is the difference's top bit, so it is 1 exactly when the minuend is the smaller value.
- R3: Registers A and B change only on a cycle where their load enable is high, and then they take the bus value. The clock is never gated. `result` is register A.
- R4: In every controller state at most one bus source is enabled. A register load always has a source enabled.
- R5: For nonzero operands, the larger register is reduced by the smaller one until the two are equal. Then `result` equals the greatest common divisor. A subtraction is written back only when it is strictly positive.
- R6: Call the clock edge that samples `start` high edge 0. For nonzero operands, `done` is first seen high after edge 3+2·S, where S is the number of subtraction steps. Equal operands give S=0. For a zero operand, `done` is high after edge 1.
- R7: Once `done` is high, it and `result` hold their values until `start` is accepted again. `start` is accepted in the finished state, and the operand inputs have no effect while `start` is low.
- R8: A `start` pulse during a computation is ignored. The result and the latency are the same as a run without that pulse.
- R9: If operand B is zero, the result is operand A. Otherwise, if operand A is zero, the result is operand B. Both zero gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (idle or finished state only) |
| opnd_a | input | W | First operand, held stable until done |
| opnd_b | input | W | Second operand, held stable until done |
| done | output | 1 | Result valid; held until the next accepted start |
| result | output | W | Greatest common divisor (register A) |

## Verification
The assertions assume that the operand inputs stay constant from the accepted start until `done`. Under that assumption, any ALU write-back during the loop is a strictly positive difference, because the flags seen in the compare state still describe the registers in the following write state. The stimulus drives every operand pair only while the engine is idle or finished, and it keeps the pair unchanged through the whole run. The only exception is the hold test, which alters the operands after `done` has risen and `start` is low. Random pairs are drawn from nonzero values, and zero operands appear only in the dedicated guard test.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  // bus source indices (one-hot select positions)
  localparam int SRC_IN_A  = 0;
  localparam int SRC_IN_B  = 1;
  localparam int SRC_REG_A = 2;
  localparam int SRC_REG_B = 3;
  localparam int SRC_ALU   = 4;
  localparam int NSRC      = 5;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_LOAD_A  = 4'd1,
    ST_LOAD_B  = 4'd2,
    ST_COMPARE = 4'd3,
    ST_SUB_A   = 4'd4,
    ST_SUB_B   = 4'd5,
    ST_GUARD_A = 4'd6,
    ST_GUARD_B = 4'd7,
    ST_DONE    = 4'd8
  } state_e;

  typedef struct packed {
    logic [NSRC-1:0] drv;
    logic            ld_a;
    logic            ld_b;
    logic            fn;
    logic            done;
  } ctrl_t;

  // Moore decode: control word as a pure function of the state
  function automatic ctrl_t decode(state_e s);
    ctrl_t c;
    c = '0;
    case (s)
      ST_LOAD_A:  begin c.drv[SRC_IN_A] = 1'b1; c.ld_a = 1'b1; end
      ST_LOAD_B:  begin c.drv[SRC_IN_B] = 1'b1; c.ld_b = 1'b1; end
      ST_COMPARE: c.fn = 1'b0;
      ST_SUB_A:   begin c.drv[SRC_ALU] = 1'b1; c.ld_a = 1'b1; c.fn = 1'b0; end
      ST_SUB_B:   begin c.drv[SRC_ALU] = 1'b1; c.ld_b = 1'b1; c.fn = 1'b1; end
      ST_GUARD_A: begin c.drv[SRC_IN_A] = 1'b1; c.ld_a = 1'b1; end
      ST_GUARD_B: begin c.drv[SRC_IN_B] = 1'b1; c.ld_a = 1'b1; end
      ST_DONE:    c.done = 1'b1;
      default:    c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/gcd_ldreg.sv
module gcd_ldreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  // feedback multiplexer instead of a gated clock
  always_comb q_nxt = ld ? d : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/gcd_alu.sv
module gcd_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         fn,
  output logic [W-1:0] diff,
  output logic         z,
  output logic         n
);
  localparam int WX = W + 1;

  logic [WX-1:0] ext_a, ext_b, minuend, subtrahend, full;

  always_comb begin
    ext_a      = {1'b0, a};
    ext_b      = {1'b0, b};
    minuend    = fn ? ext_b : ext_a;
    subtrahend = fn ? ext_a : ext_b;
    full       = minuend - subtrahend;
    diff       = full[W-1:0];
    z          = (full == '0);
    n          = full[WX-1];
  end
endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
  import gcd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [NSRC-1:0] drv,
  input  logic            ld_a,
  input  logic            ld_b,
  input  logic            fn,
  output logic            z,
  output logic            n,
  output logic            a_zero,
  output logic            b_zero,
  output logic [W-1:0]    reg_a
);
  logic [W-1:0] reg_b;
  logic [W-1:0] alu_y;
  logic [W-1:0] bus;
  logic [W-1:0] src  [NSRC];
  logic [W-1:0] term [NSRC];

  assign src[SRC_IN_A]  = opnd_a;
  assign src[SRC_IN_B]  = opnd_b;
  assign src[SRC_REG_A] = reg_a;
  assign src[SRC_REG_B] = reg_b;
  assign src[SRC_ALU]   = alu_y;

  // shared bus: AND-OR of one-hot selected drivers
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_drv
    assign term[gi] = drv[gi] ? src[gi] : '0;
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | term[i];
  end

  gcd_ldreg #(.W(W)) u_reg_a (.clk(clk), .rst(rst), .ld(ld_a), .d(bus), .q(reg_a));
  gcd_ldreg #(.W(W)) u_reg_b (.clk(clk), .rst(rst), .ld(ld_b), .d(bus), .q(reg_b));

  gcd_alu #(.W(W)) u_alu (
    .a(reg_a), .b(reg_b), .fn(fn), .diff(alu_y), .z(z), .n(n)
  );

  // start-time guard on the operand inputs
  assign a_zero = (opnd_a == '0);
  assign b_zero = (opnd_b == '0);
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  z,
  input  logic  n,
  input  logic  a_zero,
  input  logic  b_zero,
  output ctrl_t ctrl
);
  state_e state, state_nxt;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          if (b_zero)      state_nxt = ST_GUARD_A;
          else if (a_zero) state_nxt = ST_GUARD_B;
          else             state_nxt = ST_LOAD_A;
        end
      end
      ST_LOAD_A:  state_nxt = ST_LOAD_B;
      ST_LOAD_B:  state_nxt = ST_COMPARE;
      ST_COMPARE: begin
        if (z)      state_nxt = ST_DONE;
        else if (n) state_nxt = ST_SUB_B;
        else        state_nxt = ST_SUB_A;
      end
      ST_SUB_A, ST_SUB_B:     state_nxt = ST_COMPARE;
      ST_GUARD_A, ST_GUARD_B: state_nxt = ST_DONE;
      default:                state_nxt = ST_IDLE;
    endcase
  end

  // state and its decoded control word are both registered
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ctrl  <= '0;
    end else begin
      state <= state_nxt;
      ctrl  <= decode(state_nxt);
    end
  end
endmodule

// File: rtl/gcd_sub_engine.sv
module gcd_sub_engine
  import gcd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         done,
  output logic [W-1:0] result
);
  ctrl_t ctrl;
  logic  z_flag, n_flag, a_zero, b_zero;

  gcd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .z(z_flag), .n(n_flag), .a_zero(a_zero), .b_zero(b_zero),
    .ctrl(ctrl)
  );

  gcd_datapath #(.W(W)) u_dp (
    .clk(clk), .rst(rst),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .drv(ctrl.drv), .ld_a(ctrl.ld_a), .ld_b(ctrl.ld_b), .fn(ctrl.fn),
    .z(z_flag), .n(n_flag), .a_zero(a_zero), .b_zero(b_zero),
    .reg_a(result)
  );

  assign done = ctrl.done;
endmodule

// File: rtl/gcd_sub_engine_chk.sv
module gcd_sub_engine_chk
  import gcd_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            done,
  input logic [W-1:0]    result,
  input logic [NSRC-1:0] drv,
  input logic            ld_a,
  input logic            ld_b,
  input logic            fn,
  input logic            z_flag,
  input logic            n_flag
);
  // R4: exclusive bus drivers
  a_r4_onehot_drive: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv));

  // R4: a load always has a source
  a_r4_load_has_driver: assert property (@(posedge clk) disable iff (rst)
    (ld_a || ld_b) |-> (drv != '0));

  // R3: register A holds without its load enable
  a_r3_result_holds: assert property (@(posedge clk) disable iff (rst)
    !ld_a |=> $stable(result));

  // R7: finished state persists without start
  a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(result)));

  // R5: write-back into A only of a positive A-B
  a_r5_sub_a_positive: assert property (@(posedge clk) disable iff (rst)
    (ld_a && drv[SRC_ALU]) |-> (!fn && !n_flag && !z_flag));

  // R5: write-back into B only of a positive B-A
  a_r5_sub_b_positive: assert property (@(posedge clk) disable iff (rst)
    (ld_b && drv[SRC_ALU]) |-> (fn && !n_flag && !z_flag));

  // R2: zero and negative flags never coincide
  a_r2_flag_exclusive: assert property (@(posedge clk) disable iff (rst)
    z_flag |-> !n_flag);
endmodule

bind gcd_sub_engine gcd_sub_engine_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .result(result),
  .drv(ctrl.drv), .ld_a(ctrl.ld_a), .ld_b(ctrl.ld_b), .fn(ctrl.fn),
  .z_flag(z_flag), .n_flag(n_flag)
);

// File: tb/gcd_sub_engine_test.sv
module gcd_sub_engine_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic         done;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gcd_sub_engine #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .done(done), .result(result)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_gcd(int a, int b);
    int x = a, y = b, t;
    if (y == 0) return x;
    if (x == 0) return y;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  function automatic int ref_steps(int a, int b);
    int x = a, y = b, s = 0;
    while (x != y) begin
      if (x > y) x = x - y; else y = y - x;
      s++;
    end
    return s;
  endfunction

  // one run; poke_at >= 0 pulses start at that latency count
  task automatic run_pair(int a, int b, int poke_at, output int lat);
    @(negedge clk);
    opnd_a = a[W-1:0];
    opnd_b = b[W-1:0];
    start  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R7 done low after accepted start", int'(done), 0);
    lat = 0;
    while (!done && lat < 4000) begin
      if (lat == poke_at) start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 done in reset", int'(done), 0);
    check("R1 result in reset", int'(result), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    check("R1 result after reset", int'(result), 0);
  endtask

  task automatic t_pair(int a, int b);
    int lat;
    run_pair(a, b, -1, lat);
    check("R5 gcd result", int'(result), ref_gcd(a, b));
    check("R6 latency", lat, 3 + 2 * ref_steps(a, b));
  endtask

  task automatic t_directed();
    t_pair(6, 6);      // R6: S=0 gives 3 cycles
    t_pair(9, 3);      // R2/R5: A larger
    t_pair(3, 9);      // R2/R5: B larger, FN=1 path
    t_pair(200, 10);   // R2: difference with top data bit set
    t_pair(10, 200);
    t_pair(255, 254);
    t_pair(1, 255);
    t_pair(128, 64);
  endtask

  task automatic t_random();
    for (int i = 0; i < 20; i++) begin
      int a = $urandom_range(255, 1);
      int b = $urandom_range(255, 1);
      t_pair(a, b);   // R5 random nonzero pairs
    end
  endtask

  task automatic t_zero_guard();
    int lat;
    run_pair(0, 37, -1, lat);
    check("R9 A zero gives B", int'(result), 37);
    check("R6 guard latency", lat, 1);
    run_pair(91, 0, -1, lat);
    check("R9 B zero gives A", int'(result), 91);
    check("R6 guard latency", lat, 1);
    run_pair(0, 0, -1, lat);
    check("R9 both zero", int'(result), 0);
  endtask

  task automatic t_ignore_start();
    int lat;
    run_pair(255, 1, 10, lat);
    check("R8 result with mid-run start", int'(result), 1);
    check("R8 latency with mid-run start", lat, 3 + 2 * 254);
  endtask

  task automatic t_hold();
    int lat;
    run_pair(84, 36, -1, lat);
    check("R7 result before hold", int'(result), 12);
    opnd_a = 8'd7;
    opnd_b = 8'd5;
    repeat (6) @(negedge clk);
    check("R7 done held", int'(done), 1);
    check("R3 result held", int'(result), 12);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    t_reset();
    t_directed();
    t_zero_guard();
    t_ignore_start();
    t_hold();
    t_random();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule